// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block is a small circular store buffer that answers forwarding lookups from a two-stage load pipeline. Each entry carries a virtual address, a physical address, a 16-byte byte-enable mask and 16 data bytes. It also holds three flags: allocated, address known and data known. Entries are set up through three write ports. An allocate port clears an entry's flags. An address port records both addresses and the mask. A data port records the bytes.

A load presents its virtual and physical addresses, its byte mask, its own position in the circular queue and a precomputed per-entry vector of the stores that are older than it. One cycle later the block returns a fast byte-hit mask and a fast data-pending flag. One cycle after that it returns the full byte mask, the forwarded bytes and three replay or flush indications: data pending, address unknown and virtual/physical disagreement. The first two carry the index of the offending store.

Matching is on the physical address. The virtual-address compare is run next to it only to detect aliasing. When several older stores write the same byte, the one nearest to the load in queue order supplies it.

Top module: `sfwd_forward_lookup`

## Requirements
- R1: Allocating an entry sets its allocated flag and clears its address-known and data-known flags. Address and data writes in the same cycle to the same index still set their flags. An entry that was re-allocated forwards nothing until its address is written again.
- R2: Byte b of a load is matched by entry i when all of these hold: the query is valid, bit i of the older vector is set, the entry is allocated with a known address, the physical addresses are equal above bit 4 (same 16-byte line), and mask bit b is set in both the entry and the load. Byte b of the data bus is bits [8b+7:8b]. Bytes that are not forwarded read as zero.
- R3: When several entries match a byte, the owner is the entry at the smallest distance d (1..DEPTH) going backward from the load position, that is, index (q_pos - d) mod DEPTH. This holds across the wrap of the queue.
- R4: The fast mask appears in the cycle after the query is sampled. The full mask, data and flags appear one cycle later and carry the same mask.
- R5: When a byte's owner has a known address but no data, that byte is not forwarded and the data-pending flag is raised. The fast version comes after one cycle and the full version after two. The index is the nearest such owner.
- R6: When any older allocated entry has an unknown address, the address-unknown flag is raised with the index of the nearest such entry. Entries with known addresses still forward.
- R7: The alias flag is raised when an older entry with a known address overlaps the load mask and its virtual-line compare disagrees with its physical-line compare.
- R8: A query with q_valid low yields all-zero masks, zero data and deasserted flags.
- R9: After reset all outputs are zero and no entry is allocated.
- R10: Entries outside the older vector, entries on another line and entries whose mask does not overlap the load's mask contribute nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_en | input | 1 | Allocate an entry |
| alloc_idx | input | IDX_W | Entry to allocate |
| addr_en | input | 1 | Write addresses and mask |
| addr_idx | input | IDX_W | Entry for the address write |
| addr_vaddr | input | VA_W | Store virtual address |
| addr_paddr | input | PA_W | Store physical address |
| addr_mask | input | BYTES | Store byte enables |
| data_en | input | 1 | Write store data |
| data_idx | input | IDX_W | Entry for the data write |
| data_bytes | input | BYTES*8 | Store data |
| q_valid | input | 1 | Lookup request |
| q_vaddr | input | VA_W | Load virtual address |
| q_paddr | input | PA_W | Load physical address |
| q_mask | input | BYTES | Load byte enables |
| q_older | input | DEPTH | Entries older than the load |
| q_pos | input | IDX_W | Load position in the circular queue |
| s1_fwd_mask | output | BYTES | Fast forwarded-byte mask |
| s1_data_inv_fast | output | 1 | Fast data-pending flag |
| s2_fwd_mask | output | BYTES | Full forwarded-byte mask |
| s2_fwd_data | output | BYTES*8 | Forwarded bytes |
| s2_data_inv | output | 1 | Data-pending flag |
| s2_data_inv_idx | output | IDX_W | Nearest pending owner |
| s2_addr_inv | output | 1 | Address-unknown flag |
| s2_addr_inv_idx | output | IDX_W | Nearest address-unknown entry |
| s2_match_inv | output | 1 | Virtual/physical disagreement |

## Verification
The hardest situation to reach is a byte whose nearest older writer has no data while a farther writer of the same byte does. The block must then report the pending store and must not fall back to the stale one. Getting there takes three steps through the ports: overlapping entries are allocated at chosen positions, the data of only the younger one is withheld, and the query position is chosen so that the scan passes the wrap point. A directed sequence builds this with both wrap directions. A random phase then mixes allocate, fill and query traffic over three shared lines and an occasionally aliasing physical address. A behavioural model follows every cycle.

// File: rtl/sfwd_pkg.sv
package sfwd_pkg;
  localparam int unsigned SFWD_LINE_BYTES = 16;
  localparam int unsigned SFWD_BYTE_W     = 8;
  typedef logic [SFWD_BYTE_W-1:0] sfwd_byte_t;
endpackage

// File: rtl/sfwd_entry_store.sv
module sfwd_entry_store
  import sfwd_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned VA_W  = 39,
  parameter int unsigned PA_W  = 36,
  parameter int unsigned BYTES = SFWD_LINE_BYTES,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned DW    = BYTES*SFWD_BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             addr_en,
  input  logic [IDX_W-1:0] addr_idx,
  input  logic [VA_W-1:0]  addr_vaddr,
  input  logic [PA_W-1:0]  addr_paddr,
  input  logic [BYTES-1:0] addr_mask,
  input  logic             data_en,
  input  logic [IDX_W-1:0] data_idx,
  input  logic [DW-1:0]    data_bytes,
  output logic [DEPTH-1:0] e_alloc,
  output logic [DEPTH-1:0] e_addr_ok,
  output logic [DEPTH-1:0] e_data_ok,
  output logic [VA_W-1:0]  e_vaddr [DEPTH],
  output logic [PA_W-1:0]  e_paddr [DEPTH],
  output logic [BYTES-1:0] e_mask  [DEPTH],
  output logic [DW-1:0]    e_data  [DEPTH]
);
  logic [DEPTH-1:0] alloc_nxt, addr_ok_nxt, data_ok_nxt;

  // flag next state: allocation clears, fills in the same cycle set
  always_comb begin
    alloc_nxt   = e_alloc;
    addr_ok_nxt = e_addr_ok;
    data_ok_nxt = e_data_ok;
    if (alloc_en) begin
      alloc_nxt[alloc_idx]   = 1'b1;
      addr_ok_nxt[alloc_idx] = 1'b0;
      data_ok_nxt[alloc_idx] = 1'b0;
    end
    if (addr_en) addr_ok_nxt[addr_idx] = 1'b1;
    if (data_en) data_ok_nxt[data_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_alloc   <= '0;
      e_addr_ok <= '0;
      e_data_ok <= '0;
    end else begin
      e_alloc   <= alloc_nxt;
      e_addr_ok <= addr_ok_nxt;
      e_data_ok <= data_ok_nxt;
    end
  end

  // payload: no reset, qualified by the flags
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic addr_we, data_we;
    assign addr_we = addr_en && (addr_idx == IDX_W'(i));
    assign data_we = data_en && (data_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (addr_we) begin
        e_vaddr[i] <= addr_vaddr;
        e_paddr[i] <= addr_paddr;
        e_mask[i]  <= addr_mask;
      end
    end

    always_ff @(posedge clk) begin
      if (data_we) e_data[i] <= data_bytes;
    end
  end
endmodule

// File: rtl/sfwd_match.sv
module sfwd_match
  import sfwd_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned VA_W  = 39,
  parameter int unsigned PA_W  = 36,
  parameter int unsigned BYTES = SFWD_LINE_BYTES,
  localparam int unsigned OFF_W = $clog2(BYTES)
) (
  input  logic             q_valid,
  input  logic [VA_W-1:0]  q_vaddr,
  input  logic [PA_W-1:0]  q_paddr,
  input  logic [BYTES-1:0] q_mask,
  input  logic [DEPTH-1:0] q_older,
  input  logic [DEPTH-1:0] e_alloc,
  input  logic [DEPTH-1:0] e_addr_ok,
  input  logic [VA_W-1:0]  e_vaddr [DEPTH],
  input  logic [PA_W-1:0]  e_paddr [DEPTH],
  input  logic [BYTES-1:0] e_mask  [DEPTH],
  output logic [BYTES-1:0] pa_hit  [DEPTH],
  output logic [DEPTH-1:0] alias_hit,
  output logic [DEPTH-1:0] unk_addr
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic cand, known, va_eq, pa_eq;
    logic [BYTES-1:0] overlap;

    assign cand    = q_valid && q_older[i] && e_alloc[i];
    assign known   = cand && e_addr_ok[i];
    assign va_eq   = (e_vaddr[i][VA_W-1:OFF_W] == q_vaddr[VA_W-1:OFF_W]);
    assign pa_eq   = (e_paddr[i][PA_W-1:OFF_W] == q_paddr[PA_W-1:OFF_W]);
    assign overlap = e_mask[i] & q_mask;

    assign pa_hit[i]    = (known && pa_eq) ? overlap : '0;
    assign alias_hit[i] = known && (va_eq != pa_eq) && (|overlap);
    assign unk_addr[i]  = cand && !e_addr_ok[i];
  end
endmodule

// File: rtl/sfwd_select.sv
module sfwd_select
  import sfwd_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BYTES = SFWD_LINE_BYTES,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned DW    = BYTES*SFWD_BYTE_W
) (
  input  logic [IDX_W-1:0] q_pos,
  input  logic [BYTES-1:0] pa_hit  [DEPTH],
  input  logic [DEPTH-1:0] alias_hit,
  input  logic [DEPTH-1:0] unk_addr,
  input  logic [DEPTH-1:0] e_data_ok,
  input  logic [DW-1:0]    e_data  [DEPTH],
  output logic [BYTES-1:0] fwd_mask,
  output logic [DW-1:0]    fwd_data,
  output logic             data_inv,
  output logic [IDX_W-1:0] data_inv_idx,
  output logic             addr_inv,
  output logic [IDX_W-1:0] addr_inv_idx,
  output logic             match_inv
);
  // nearest set bit walking backward from the load position
  function automatic logic [IDX_W-1:0] pick_nearest(input logic [DEPTH-1:0] v,
                                                    input logic [IDX_W-1:0] pos);
    logic [IDX_W-1:0] r, k;
    r = '0;
    for (int d = DEPTH; d >= 1; d--) begin
      k = pos - IDX_W'(d);
      if (v[k]) r = k;
    end
    return r;
  endfunction

  logic [DEPTH-1:0] owner_oh [BYTES];
  logic [DEPTH-1:0] pend_ent;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [DEPTH-1:0] col;
    always_comb begin
      for (int i = 0; i < DEPTH; i++) col[i] = pa_hit[i][b];
    end

    always_comb begin
      owner_oh[b] = '0;
      if (|col) owner_oh[b][pick_nearest(col, q_pos)] = 1'b1;
    end

    always_comb begin
      fwd_mask[b] = |(owner_oh[b] & e_data_ok);
      fwd_data[b*SFWD_BYTE_W +: SFWD_BYTE_W] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (owner_oh[b][i] && e_data_ok[i])
          fwd_data[b*SFWD_BYTE_W +: SFWD_BYTE_W] = e_data[i][b*SFWD_BYTE_W +: SFWD_BYTE_W];
      end
    end
  end

  always_comb begin
    pend_ent = '0;
    for (int b = 0; b < BYTES; b++) pend_ent |= owner_oh[b] & ~e_data_ok;
  end

  assign data_inv     = |pend_ent;
  assign data_inv_idx = pick_nearest(pend_ent, q_pos);
  assign addr_inv     = |unk_addr;
  assign addr_inv_idx = pick_nearest(unk_addr, q_pos);
  assign match_inv    = |alias_hit;
endmodule

// File: rtl/sfwd_forward_lookup.sv
module sfwd_forward_lookup
  import sfwd_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned VA_W  = 39,
  parameter int unsigned PA_W  = 36,
  parameter int unsigned BYTES = SFWD_LINE_BYTES,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned DW    = BYTES*SFWD_BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             addr_en,
  input  logic [IDX_W-1:0] addr_idx,
  input  logic [VA_W-1:0]  addr_vaddr,
  input  logic [PA_W-1:0]  addr_paddr,
  input  logic [BYTES-1:0] addr_mask,
  input  logic             data_en,
  input  logic [IDX_W-1:0] data_idx,
  input  logic [DW-1:0]    data_bytes,
  input  logic             q_valid,
  input  logic [VA_W-1:0]  q_vaddr,
  input  logic [PA_W-1:0]  q_paddr,
  input  logic [BYTES-1:0] q_mask,
  input  logic [DEPTH-1:0] q_older,
  input  logic [IDX_W-1:0] q_pos,
  output logic [BYTES-1:0] s1_fwd_mask,
  output logic             s1_data_inv_fast,
  output logic [BYTES-1:0] s2_fwd_mask,
  output logic [DW-1:0]    s2_fwd_data,
  output logic             s2_data_inv,
  output logic [IDX_W-1:0] s2_data_inv_idx,
  output logic             s2_addr_inv,
  output logic [IDX_W-1:0] s2_addr_inv_idx,
  output logic             s2_match_inv
);
  typedef struct packed {
    logic [BYTES-1:0] mask;
    logic [DW-1:0]    data;
    logic             dinv;
    logic [IDX_W-1:0] dinv_idx;
    logic             ainv;
    logic [IDX_W-1:0] ainv_idx;
    logic             minv;
  } stage_t;

  logic [DEPTH-1:0] e_alloc, e_addr_ok, e_data_ok;
  logic [VA_W-1:0]  e_vaddr [DEPTH];
  logic [PA_W-1:0]  e_paddr [DEPTH];
  logic [BYTES-1:0] e_mask  [DEPTH];
  logic [DW-1:0]    e_data  [DEPTH];
  logic [BYTES-1:0] pa_hit  [DEPTH];
  logic [DEPTH-1:0] alias_hit, unk_addr;
  stage_t           lookup;

  sfwd_entry_store #(.DEPTH(DEPTH), .VA_W(VA_W), .PA_W(PA_W), .BYTES(BYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_en), .alloc_idx(alloc_idx),
    .addr_en(addr_en), .addr_idx(addr_idx), .addr_vaddr(addr_vaddr),
    .addr_paddr(addr_paddr), .addr_mask(addr_mask),
    .data_en(data_en), .data_idx(data_idx), .data_bytes(data_bytes),
    .e_alloc(e_alloc), .e_addr_ok(e_addr_ok), .e_data_ok(e_data_ok),
    .e_vaddr(e_vaddr), .e_paddr(e_paddr), .e_mask(e_mask), .e_data(e_data)
  );

  sfwd_match #(.DEPTH(DEPTH), .VA_W(VA_W), .PA_W(PA_W), .BYTES(BYTES)) u_match (
    .q_valid(q_valid), .q_vaddr(q_vaddr), .q_paddr(q_paddr), .q_mask(q_mask),
    .q_older(q_older), .e_alloc(e_alloc), .e_addr_ok(e_addr_ok),
    .e_vaddr(e_vaddr), .e_paddr(e_paddr), .e_mask(e_mask),
    .pa_hit(pa_hit), .alias_hit(alias_hit), .unk_addr(unk_addr)
  );

  sfwd_select #(.DEPTH(DEPTH), .BYTES(BYTES)) u_select (
    .q_pos(q_pos), .pa_hit(pa_hit), .alias_hit(alias_hit), .unk_addr(unk_addr),
    .e_data_ok(e_data_ok), .e_data(e_data),
    .fwd_mask(lookup.mask), .fwd_data(lookup.data),
    .data_inv(lookup.dinv), .data_inv_idx(lookup.dinv_idx),
    .addr_inv(lookup.ainv), .addr_inv_idx(lookup.ainv_idx),
    .match_inv(lookup.minv)
  );

  // two result stages with explicit clock enables
  stage_t s1_q, s1_nxt, s2_q, s2_nxt;
  logic   s1_vld, s2_vld, s1_en, s2_en;

  assign s1_en = q_valid | s1_vld;
  assign s2_en = s1_vld  | s2_vld;

  always_comb begin
    s1_nxt = s1_q;
    s2_nxt = s2_q;
    if (s1_en) s1_nxt = lookup;
    if (s2_en) s2_nxt = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      s1_q   <= s1_nxt;
      s2_q   <= s2_nxt;
      s1_vld <= q_valid;
      s2_vld <= s1_vld;
    end
  end

  assign s1_fwd_mask      = s1_q.mask;
  assign s1_data_inv_fast = s1_q.dinv;
  assign s2_fwd_mask      = s2_q.mask;
  assign s2_fwd_data      = s2_q.data;
  assign s2_data_inv      = s2_q.dinv;
  assign s2_data_inv_idx  = s2_q.dinv_idx;
  assign s2_addr_inv      = s2_q.ainv;
  assign s2_addr_inv_idx  = s2_q.ainv_idx;
  assign s2_match_inv     = s2_q.minv;
endmodule

// File: rtl/sfwd_checker.sv
module sfwd_checker
  import sfwd_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BYTES = SFWD_LINE_BYTES,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned DW    = BYTES*SFWD_BYTE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             q_valid,
  input logic [BYTES-1:0] q_mask,
  input logic [DEPTH-1:0] q_older,
  input logic [BYTES-1:0] s1_fwd_mask,
  input logic             s1_data_inv_fast,
  input logic [BYTES-1:0] s2_fwd_mask,
  input logic [DW-1:0]    s2_fwd_data,
  input logic             s2_data_inv,
  input logic             s2_addr_inv,
  input logic             s2_match_inv
);
  logic [BYTES-1:0] stray;
  always_comb begin
    for (int b = 0; b < BYTES; b++)
      stray[b] = !s2_fwd_mask[b] && (|s2_fwd_data[b*SFWD_BYTE_W +: SFWD_BYTE_W]);
  end

  // R2: forwarded bytes are a subset of the load's bytes
  assert_mask_in_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(q_valid) |-> ((s1_fwd_mask & ~$past(q_mask)) == '0));

  // R2: unforwarded bytes read as zero
  assert_unforwarded_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stray == '0);

  // R8: idle query gives quiet fast outputs
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(q_valid) |-> (s1_fwd_mask == '0 && !s1_data_inv_fast));

  // R10: no older entries means nothing to report
  assert_no_older_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(q_valid) && $past(q_older) == '0) |-> (s1_fwd_mask == '0 && !s1_data_inv_fast));

  // R4: full mask stays within the load mask two cycles back
  assert_full_mask_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(q_valid, 2) |-> ((s2_fwd_mask & ~$past(q_mask, 2)) == '0));

  // R8: stage-2 flags stay low two cycles after an idle query
  assert_idle_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(q_valid, 2) |-> (!s2_data_inv && !s2_addr_inv && !s2_match_inv));
endmodule

bind sfwd_forward_lookup sfwd_checker #(.DEPTH(DEPTH), .BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_mask(q_mask), .q_older(q_older),
  .s1_fwd_mask(s1_fwd_mask), .s1_data_inv_fast(s1_data_inv_fast),
  .s2_fwd_mask(s2_fwd_mask), .s2_fwd_data(s2_fwd_data), .s2_data_inv(s2_data_inv),
  .s2_addr_inv(s2_addr_inv), .s2_match_inv(s2_match_inv)
);

// File: tb/sfwd_forward_lookup_tb.sv
module sfwd_forward_lookup_tb;
  localparam int DEPTH = 8;
  localparam int VA_W  = 39;
  localparam int PA_W  = 36;
  localparam int BYTES = 16;
  localparam int IDX_W = 3;
  localparam int DW    = 128;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic             alloc_en, addr_en, data_en, q_valid;
  logic [IDX_W-1:0] alloc_idx, addr_idx, data_idx, q_pos;
  logic [VA_W-1:0]  addr_vaddr, q_vaddr;
  logic [PA_W-1:0]  addr_paddr, q_paddr;
  logic [BYTES-1:0] addr_mask, q_mask;
  logic [DW-1:0]    data_bytes;
  logic [DEPTH-1:0] q_older;
  logic [BYTES-1:0] s1_fwd_mask, s2_fwd_mask;
  logic             s1_data_inv_fast, s2_data_inv, s2_addr_inv, s2_match_inv;
  logic [DW-1:0]    s2_fwd_data;
  logic [IDX_W-1:0] s2_data_inv_idx, s2_addr_inv_idx;

  sfwd_forward_lookup #(.DEPTH(DEPTH), .VA_W(VA_W), .PA_W(PA_W), .BYTES(BYTES)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_en), .alloc_idx(alloc_idx),
    .addr_en(addr_en), .addr_idx(addr_idx), .addr_vaddr(addr_vaddr),
    .addr_paddr(addr_paddr), .addr_mask(addr_mask),
    .data_en(data_en), .data_idx(data_idx), .data_bytes(data_bytes),
    .q_valid(q_valid), .q_vaddr(q_vaddr), .q_paddr(q_paddr), .q_mask(q_mask),
    .q_older(q_older), .q_pos(q_pos),
    .s1_fwd_mask(s1_fwd_mask), .s1_data_inv_fast(s1_data_inv_fast),
    .s2_fwd_mask(s2_fwd_mask), .s2_fwd_data(s2_fwd_data),
    .s2_data_inv(s2_data_inv), .s2_data_inv_idx(s2_data_inv_idx),
    .s2_addr_inv(s2_addr_inv), .s2_addr_inv_idx(s2_addr_inv_idx),
    .s2_match_inv(s2_match_inv)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R9";
  bit    cmp_on = 1'b0;

  task automatic check(string req, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit       m_alloc [DEPTH];
  bit       m_av    [DEPTH];
  bit       m_dv    [DEPTH];
  logic [VA_W-1:0] m_va [DEPTH];
  logic [PA_W-1:0] m_pa [DEPTH];
  logic [BYTES-1:0] m_mask [DEPTH];
  logic [DW-1:0]    m_data [DEPTH];

  logic [BYTES-1:0] x1_mask, x2_mask;
  logic [DW-1:0]    x1_data, x2_data;
  logic             x1_dinv, x2_dinv, x1_ainv, x2_ainv, x1_minv, x2_minv;
  int               x1_didx, x2_didx, x1_aidx, x2_aidx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin m_alloc[i] = 0; m_av[i] = 0; m_dv[i] = 0; end
      x1_mask = '0; x1_data = '0; x1_dinv = 0; x1_ainv = 0; x1_minv = 0; x1_didx = 0; x1_aidx = 0;
      x2_mask = '0; x2_data = '0; x2_dinv = 0; x2_ainv = 0; x2_minv = 0; x2_didx = 0; x2_aidx = 0;
    end else begin
      bit pend [DEPTH];
      x2_mask = x1_mask; x2_data = x1_data; x2_dinv = x1_dinv; x2_didx = x1_didx;
      x2_ainv = x1_ainv; x2_aidx = x1_aidx; x2_minv = x1_minv;
      x1_mask = '0; x1_data = '0; x1_dinv = 0; x1_ainv = 0; x1_minv = 0; x1_didx = 0; x1_aidx = 0;
      for (int i = 0; i < DEPTH; i++) pend[i] = 0;
      if (q_valid) begin
        for (int b = 0; b < BYTES; b++) begin
          int owner;
          owner = -1;
          for (int d = 1; d <= DEPTH; d++) begin
            int i;
            i = (int'(q_pos) - d + DEPTH) % DEPTH;
            if (owner < 0 && q_older[i] && m_alloc[i] && m_av[i] &&
                (m_pa[i] >> 4) == (q_paddr >> 4) && m_mask[i][b] && q_mask[b])
              owner = i;
          end
          if (owner >= 0) begin
            if (m_dv[owner]) begin
              x1_mask[b] = 1'b1;
              x1_data[b*8 +: 8] = m_data[owner][b*8 +: 8];
            end else pend[owner] = 1;
          end
        end
        for (int d = DEPTH; d >= 1; d--) begin
          int i;
          i = (int'(q_pos) - d + DEPTH) % DEPTH;
          if (pend[i]) begin x1_dinv = 1; x1_didx = i; end
          if (q_older[i] && m_alloc[i] && !m_av[i]) begin x1_ainv = 1; x1_aidx = i; end
          if (q_older[i] && m_alloc[i] && m_av[i] && ((m_mask[i] & q_mask) != 0) &
              (((m_va[i] >> 4) == (q_vaddr >> 4)) != ((m_pa[i] >> 4) == (q_paddr >> 4))))
            x1_minv = 1;
        end
      end
      if (alloc_en) begin m_alloc[alloc_idx] = 1; m_av[alloc_idx] = 0; m_dv[alloc_idx] = 0; end
      if (addr_en) begin
        m_av[addr_idx] = 1; m_va[addr_idx] = addr_vaddr;
        m_pa[addr_idx] = addr_paddr; m_mask[addr_idx] = addr_mask;
      end
      if (data_en) begin m_dv[data_idx] = 1; m_data[data_idx] = data_bytes; end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check(cur_req, "s1_fwd_mask", DW'(s1_fwd_mask), DW'(x1_mask));
      check(cur_req, "s1_data_inv_fast", DW'(s1_data_inv_fast), DW'(x1_dinv));
      check(cur_req, "s2_fwd_mask", DW'(s2_fwd_mask), DW'(x2_mask));
      check(cur_req, "s2_fwd_data", s2_fwd_data, x2_data);
      check(cur_req, "s2_data_inv", DW'({s2_data_inv, s2_data_inv_idx}), DW'({x2_dinv, 3'(x2_didx)}));
      check(cur_req, "s2_addr_inv", DW'({s2_addr_inv, s2_addr_inv_idx}), DW'({x2_ainv, 3'(x2_aidx)}));
      check(cur_req, "s2_match_inv", DW'(s2_match_inv), DW'(x2_minv));
    end
  end

  // ---------------- stimulus helpers ----------------
  localparam logic [VA_W-1:0] VA0 = 39'h40_0000_1230;
  localparam logic [PA_W-1:0] PA0 = 36'h0_8000_5670;
  localparam logic [PA_W-1:0] PA1 = 36'h0_8000_9990;

  function automatic logic [DW-1:0] pat(int e);
    logic [DW-1:0] r;
    for (int j = 0; j < BYTES; j++) r[j*8 +: 8] = 8'(e*16 + j);
    return r;
  endfunction

  task automatic idle_inputs();
    alloc_en = 0; addr_en = 0; data_en = 0; q_valid = 0;
  endtask

  task automatic put_store(int idx, logic [VA_W-1:0] va, logic [PA_W-1:0] pa,
                           logic [BYTES-1:0] m, bit with_data);
    alloc_en = 1; alloc_idx = 3'(idx);
    addr_en = 1; addr_idx = 3'(idx); addr_vaddr = va; addr_paddr = pa; addr_mask = m;
    data_en = with_data; data_idx = 3'(idx); data_bytes = pat(idx);
    @(negedge clk); idle_inputs();
  endtask

  task automatic put_data(int idx);
    data_en = 1; data_idx = 3'(idx); data_bytes = pat(idx);
    @(negedge clk); idle_inputs();
  endtask

  task automatic put_alloc(int idx);
    alloc_en = 1; alloc_idx = 3'(idx);
    @(negedge clk); idle_inputs();
  endtask

  // returns at the negedge where stage-1 results are visible
  task automatic lookup(bit v, logic [VA_W-1:0] va, logic [PA_W-1:0] pa,
                        logic [BYTES-1:0] m, logic [DEPTH-1:0] older, int pos);
    q_valid = v; q_vaddr = va; q_paddr = pa; q_mask = m; q_older = older; q_pos = 3'(pos);
    @(negedge clk); idle_inputs();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    alloc_idx = '0; addr_idx = '0; data_idx = '0; q_pos = '0;
    addr_vaddr = '0; addr_paddr = '0; addr_mask = '0; data_bytes = '0;
    q_vaddr = '0; q_paddr = '0; q_mask = '0; q_older = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "reset s1 mask", DW'(s1_fwd_mask), '0);
    check("R9", "reset s2 data", s2_fwd_data, '0);
    check("R9", "reset flags", DW'({s2_data_inv, s2_addr_inv, s2_match_inv, s1_data_inv_fast}), '0);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;

    // R2: basic forward of low half
    cur_req = "R2";
    put_store(0, VA0, PA0, 16'h00FF, 1);
    lookup(1, VA0 + 4, PA0 + 4, 16'hFFFF, 8'h01, 1);
    check("R4", "fast mask timing", DW'(s1_fwd_mask), DW'(16'h00FF));
    @(negedge clk);
    check("R2", "forwarded data", s2_fwd_data, {64'h0, pat(0)[63:0]});

    // R1: re-allocation clears address and data knowledge
    cur_req = "R1";
    put_alloc(0);
    lookup(1, VA0, PA0, 16'hFFFF, 8'h01, 1);
    @(negedge clk);
    check("R1", "realloc mask", DW'(s2_fwd_mask), '0);
    check("R6", "realloc addr unknown", DW'({s2_addr_inv, s2_addr_inv_idx}), DW'({1'b1, 3'd0}));
    put_store(0, VA0, PA0, 16'h00FF, 1);

    // R3: overlap, nearer store wins
    cur_req = "R3";
    put_store(1, VA0, PA0, 16'h0FF0, 1);
    lookup(1, VA0, PA0, 16'hFFFF, 8'h03, 2);
    @(negedge clk);
    check("R3", "overlap mask", DW'(s2_fwd_mask), DW'(16'h0FFF));
    check("R3", "byte2 from e0", DW'(s2_fwd_data[23:16]), DW'(8'h02));
    check("R3", "byte5 from e1", DW'(s2_fwd_data[47:40]), DW'(8'h15));

    // R3: wrap of the queue
    put_store(7, VA0, PA0, 16'h00F0, 1);
    lookup(1, VA0, PA0, 16'hFFFF, 8'h81, 1);
    @(negedge clk);
    check("R3", "wrap pos1 byte5 from e0", DW'(s2_fwd_data[47:40]), DW'(8'h05));
    lookup(1, VA0, PA0, 16'hFFFF, 8'h81, 0);
    @(negedge clk);
    check("R3", "wrap pos0 byte5 from e7", DW'(s2_fwd_data[47:40]), DW'(8'h75));

    // R5: nearest owner has no data
    cur_req = "R5";
    put_store(2, VA0, PA0, 16'h000F, 0);
    lookup(1, VA0, PA0, 16'hFFFF, 8'h07, 3);
    check("R5", "fast pending", DW'(s1_data_inv_fast), DW'(1'b1));
    @(negedge clk);
    check("R5", "pending mask", DW'(s2_fwd_mask), DW'(16'h0FF0));
    check("R5", "pending idx", DW'({s2_data_inv, s2_data_inv_idx}), DW'({1'b1, 3'd2}));
    put_data(2);
    lookup(1, VA0, PA0, 16'hFFFF, 8'h07, 3);
    @(negedge clk);
    check("R5", "filled byte1", DW'(s2_fwd_data[15:8]), DW'(8'h21));
    check("R5", "filled no pending", DW'(s2_data_inv), '0);

    // R6: unknown address among older stores
    cur_req = "R6";
    put_alloc(3);
    lookup(1, VA0, PA0, 16'hFFFF, 8'h0F, 4);
    @(negedge clk);
    check("R6", "addr unknown idx3", DW'({s2_addr_inv, s2_addr_inv_idx}), DW'({1'b1, 3'd3}));
    check("R6", "known still forward", DW'(s2_fwd_mask), DW'(16'h0FFF));

    // R7: virtual line matches, physical line differs
    cur_req = "R7";
    put_store(4, VA0, PA1, 16'hF000, 1);
    lookup(1, VA0, PA0, 16'hFFFF, 8'h17, 5);
    @(negedge clk);
    check("R7", "alias flag", DW'(s2_match_inv), DW'(1'b1));
    check("R7", "alias bytes not forwarded", DW'(s2_fwd_mask), DW'(16'h0FFF));

    // R10: excluded, other-line and disjoint-mask entries
    cur_req = "R10";
    lookup(1, VA0, PA0, 16'hFFFF, 8'h00, 5);
    @(negedge clk);
    check("R10", "no older", DW'(s2_fwd_mask), '0);
    lookup(1, VA0 + 39'h100, PA0 + 36'h100, 16'hFFFF, 8'h87, 3);
    @(negedge clk);
    check("R10", "other line", DW'(s2_fwd_mask), '0);
    lookup(1, VA0, PA0, 16'hF000, 8'h87, 3);
    @(negedge clk);
    check("R10", "disjoint mask", DW'(s2_fwd_mask), '0);

    // R8: invalid query
    cur_req = "R8";
    lookup(0, VA0, PA0, 16'hFFFF, 8'hFF, 5);
    @(negedge clk);
    check("R8", "idle outputs", DW'({s2_fwd_mask, s2_data_inv, s2_addr_inv, s2_match_inv}), '0);

    // random traffic against the model
    cur_req = "R2";
    for (int n = 0; n < 1500; n++) begin
      int e;
      logic [VA_W-1:0] va;
      e = $urandom_range(0, 2);
      va = VA0 + VA_W'(e * 16);
      alloc_en = ($urandom_range(0, 5) == 0); alloc_idx = 3'($urandom_range(0, 7));
      addr_en = ($urandom_range(0, 2) == 0); addr_idx = 3'($urandom_range(0, 7));
      addr_vaddr = va + VA_W'($urandom_range(0, 15));
      addr_paddr = ($urandom_range(0, 7) == 0) ? PA1 : PA0 + PA_W'(e * 16);
      addr_mask = 16'($urandom);
      data_en = ($urandom_range(0, 2) == 0); data_idx = 3'($urandom_range(0, 7));
      data_bytes = {$urandom, $urandom, $urandom, $urandom};
      q_valid = ($urandom_range(0, 3) != 0);
      e = $urandom_range(0, 2);
      q_vaddr = VA0 + VA_W'(e * 16);
      q_paddr = PA0 + PA_W'(e * 16);
      q_mask = 16'($urandom);
      q_older = 8'($urandom);
      q_pos = 3'($urandom_range(0, 7));
      @(negedge clk);
    end
    idle_inputs();
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule